// File: doc/BRIEF.md
# Synchronous Loadable Binary Up Counter with Cascade Carry

This block is a four-bit binary counter in which every change of state happens on the rising clock edge. Two separate enable inputs must both be high for the count to advance. One of them, the cascade enable, also qualifies the terminal-count carry. Several instances can therefore be chained: the carry of one stage drives the cascade enable of the next, and one shared count enable starts or stops the whole chain.

The counter has two control inputs, both active low and sampled on the clock. The clear input forces the count to zero and overrides everything else. The load input copies a four-bit value into the count whatever the enables are. Loading a start value lets the user shorten or shift the counting sequence. The carry output is combinational, so a chained stage sees it in the same cycle the terminal count appears.

Top module: `sync_load_counter`

## Requirements
- R1: When `clr_n` is 0 at a rising edge, the count becomes 0000 after that edge, whatever `load_n`, `cnt_en` and `casc_en` are.
- R2: When `clr_n` is 1 and `load_n` is 0 at a rising edge, the count takes the value of `load_val` after that edge, whatever the two enables are.
- R3: When `clr_n` and `load_n` are 1 and both `cnt_en` and `casc_en` are 1 at a rising edge, the count increases by one.
- R4: When `clr_n` and `load_n` are 1 and either `cnt_en` or `casc_en` is 0 at a rising edge, the count keeps its value.
- R5: Advancing from 1111 gives 0000.
- R6: `carry_out` is 1 in the same cycle in which the count is 1111 and `casc_en` is 1, with no register in between, and 0 at every other count.
- R7: While `casc_en` is 0, `carry_out` is 0, even when the count is 1111.
- R8: Starting from a clear with both enables held at 1, the count passes through 0000 to 1111 in ascending binary order, one step per clock.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock. All state changes happen on its rising edge |
| clr_n | input | 1 | Synchronous clear, active low, highest priority |
| load_n | input | 1 | Synchronous parallel load, active low |
| cnt_en | input | 1 | Count enable. It does not affect the carry |
| casc_en | input | 1 | Cascade enable. It gates both counting and the carry |
| load_val | input | 4 | Value copied into the count on a load |
| count | output | 4 | Current count. Bit 0 is the least significant bit |
| carry_out | output | 1 | Terminal-count carry, qualified by `casc_en` |

## Verification
On every cycle after the first clear, the assertions check the next-state rules: clearing, loading, stepping by one, holding and wrapping. They also check that the carry agrees with `casc_en` and a full count.

Some behaviour only the bench's scenarios can show. These are the full ascending pass from zero, clear winning over a load that is asserted at the same time, and a load with both enables low. They also include the carry going low at once when `casc_en` drops while the count is at 1111. A cycle-by-cycle reference model covers all of these and compares the count and the carry every clock.

// File: rtl/slc_pkg.sv
package slc_pkg;

    // Action the counter takes at the next rising edge, listed in priority order.
    typedef enum logic [1:0] {
        OP_CLEAR = 2'd0,
        OP_LOAD  = 2'd1,
        OP_STEP  = 2'd2,
        OP_HOLD  = 2'd3
    } slc_op_e;

endpackage

// File: rtl/slc_ctrl.sv
module slc_ctrl
    import slc_pkg::*;
(
    input  logic    clr_n,
    input  logic    load_n,
    input  logic    cnt_en,
    input  logic    casc_en,
    output slc_op_e op
);

    // Clear beats load. Load beats counting and ignores the enables.
    always_comb begin
        if (!clr_n) begin
            op = OP_CLEAR;
        end else if (!load_n) begin
            op = OP_LOAD;
        end else if (cnt_en && casc_en) begin
            op = OP_STEP;
        end else begin
            op = OP_HOLD;
        end
    end

endmodule

// File: rtl/slc_incr.sv
module slc_incr #(
    parameter int WIDTH = 4
) (
    input  logic [WIDTH-1:0] value,
    output logic [WIDTH-1:0] plus_one,
    output logic             all_ones
);

    // c[i] is 1 when every bit below position i is 1.
    logic [WIDTH:0] c;

    assign c[0] = 1'b1;

    // One half-adder stage per bit. The final stage output marks a full count.
    for (genvar i = 0; i < WIDTH; i++) begin : g_bit
        assign plus_one[i] = value[i] ^ c[i];
        assign c[i+1]      = value[i] & c[i];
    end

    assign all_ones = c[WIDTH];

endmodule

// File: rtl/slc_carry.sv
module slc_carry (
    input  logic casc_en,
    input  logic at_top,
    output logic carry_out
);

    // No register here, so a chained stage sees the carry in the same cycle.
    assign carry_out = casc_en & at_top;

endmodule

// File: rtl/sync_load_counter.sv
module sync_load_counter
    import slc_pkg::*;
#(
    parameter int WIDTH = 4
) (
    input  logic             clk,
    input  logic             clr_n,
    input  logic             load_n,
    input  logic             cnt_en,
    input  logic             casc_en,
    input  logic [WIDTH-1:0] load_val,
    output logic [WIDTH-1:0] count,
    output logic             carry_out
);

    localparam logic [WIDTH-1:0] ZERO = '0;

    typedef struct packed {
        logic [WIDTH-1:0] cnt;
    } state_t;

    state_t          state_d;
    state_t          state_q;
    slc_op_e         op;
    logic [WIDTH-1:0] inc_val;
    logic            full;

    slc_ctrl u_ctrl (
        .clr_n   (clr_n),
        .load_n  (load_n),
        .cnt_en  (cnt_en),
        .casc_en (casc_en),
        .op      (op)
    );

    slc_incr #(.WIDTH(WIDTH)) u_incr (
        .value    (state_q.cnt),
        .plus_one (inc_val),
        .all_ones (full)
    );

    slc_carry u_carry (
        .casc_en   (casc_en),
        .at_top    (full),
        .carry_out (carry_out)
    );

    always_comb begin
        state_d = state_q;
        unique case (op)
            OP_CLEAR: state_d.cnt = ZERO;
            OP_LOAD:  state_d.cnt = load_val;
            OP_STEP:  state_d.cnt = inc_val;
            default:  state_d.cnt = state_q.cnt;
        endcase
    end

    always_ff @(posedge clk) begin
        state_q <= state_d;
    end

    assign count = state_q.cnt;

endmodule

// File: rtl/slc_checker.sv
module slc_checker #(
    parameter int WIDTH = 4
) (
    input logic             clk,
    input logic             clr_n,
    input logic             load_n,
    input logic             cnt_en,
    input logic             casc_en,
    input logic [WIDTH-1:0] load_val,
    input logic [WIDTH-1:0] count,
    input logic             carry_out
);

    // The count is undefined until the first clear. The checks start after it.
    logic primed_q = 1'b0;

    always_ff @(posedge clk) begin
        if (!clr_n) primed_q <= 1'b1;
    end

    // R1
    clear_wins_chk: assert property (@(posedge clk) disable iff (!primed_q)
        !clr_n |=> count == '0);

    // R2
    load_takes_value_chk: assert property (@(posedge clk) disable iff (!primed_q)
        (clr_n && !load_n) |=> count == $past(load_val));

    // R3
    step_by_one_chk: assert property (@(posedge clk) disable iff (!primed_q)
        (clr_n && load_n && cnt_en && casc_en) |=> count == WIDTH'($past(count) + 1'b1));

    // R4
    hold_when_disabled_chk: assert property (@(posedge clk) disable iff (!primed_q)
        (clr_n && load_n && !(cnt_en && casc_en)) |=> $stable(count));

    // R5
    wrap_to_zero_chk: assert property (@(posedge clk) disable iff (!primed_q)
        (clr_n && load_n && cnt_en && casc_en && (&count)) |=> count == '0);

    // R6
    carry_needs_top_chk: assert property (@(posedge clk) disable iff (!primed_q)
        carry_out |-> (&count));

    // R6
    carry_at_top_chk: assert property (@(posedge clk) disable iff (!primed_q)
        ((&count) && casc_en) |-> carry_out);

    // R7
    carry_gated_chk: assert property (@(posedge clk) disable iff (!primed_q)
        !casc_en |-> !carry_out);

endmodule

bind sync_load_counter slc_checker #(.WIDTH(WIDTH)) u_slc_checker (
    .clk       (clk),
    .clr_n     (clr_n),
    .load_n    (load_n),
    .cnt_en    (cnt_en),
    .casc_en   (casc_en),
    .load_val  (load_val),
    .count     (count),
    .carry_out (carry_out)
);

// File: tb/sync_load_counter_bench.sv
module sync_load_counter_bench;

    logic       clk = 1'b0;
    logic       clr_n = 1'b1;
    logic       load_n = 1'b1;
    logic       cnt_en = 1'b0;
    logic       casc_en = 1'b0;
    logic [3:0] load_val = 4'd0;
    logic [3:0] count;
    logic       carry_out;

    int checks = 0;
    int errors = 0;
    int model = 0;
    bit done = 1'b0;

    always #5 clk = ~clk;

    sync_load_counter u_sync_load_counter (
        .clk       (clk),
        .clr_n     (clr_n),
        .load_n    (load_n),
        .cnt_en    (cnt_en),
        .casc_en   (casc_en),
        .load_val  (load_val),
        .count     (count),
        .carry_out (carry_out)
    );

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    // Set the inputs after a falling edge and check the carry straight away.
    // Update the model at the rising edge, then check the count at the next
    // falling edge.
    task automatic step(input string tag, input bit c, input bit l,
                        input bit ce, input bit te, input int v);
        clr_n = c; load_n = l; cnt_en = ce; casc_en = te; load_val = 4'(v);
        #1;
        chk({tag, " carry (R6/R7)"}, int'(carry_out), (te && model == 15) ? 1 : 0);
        @(posedge clk);
        if (!c)            model = 0;
        else if (!l)       model = v;
        else if (ce && te) model = (model + 1) % 16;
        @(negedge clk);
        chk({tag, " count"}, int'(count), model);
    endtask

    initial begin
        @(negedge clk);
        step("R1 reset clear", 0, 1, 1, 1, 9);
        for (int i = 0; i < 20; i++) step("R8 R3 R5 ascending", 1, 1, 1, 1, 0);
        step("R2 load with enables low", 1, 0, 0, 0, 13);
        step("R4 hold cnt_en low", 1, 1, 0, 1, 0);
        step("R4 hold casc_en low", 1, 1, 1, 0, 0);
        step("R2 load top", 1, 0, 1, 1, 15);
        step("R7 carry gated at top", 1, 1, 1, 0, 0);
        step("R6 R5 wrap from top", 1, 1, 1, 1, 0);
        step("R2 load 6", 1, 0, 0, 1, 6);
        step("R1 clear beats load", 0, 0, 1, 1, 11);
        step("R3 step after clear", 1, 1, 1, 1, 0);
        step("R2 load top again", 1, 0, 0, 0, 15);
        step("R6 R4 hold at top", 1, 1, 0, 1, 0);
        step("R1 clear at top", 0, 1, 0, 0, 0);
        done = 1'b1;
    end

    initial begin
        fork
            wait (done);
            begin
                repeat (2000) @(posedge clk);
                checks++;
                errors++;
                $display("FAIL watchdog: actual timeout expected completion");
            end
        join_any
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

endmodule